// File: doc/BRIEF.md
# Decimal Next Program Counter Unit

This block decides where a small decimal processor fetches its next instruction. Every word is four decimal digits held as packed BCD, one nibble per digit, and negative quantities are held in ten's complement, so that 9999 stands for -1. Each cycle the decoder presents the current program counter, an operation class, a condition selector, the two source register values, two immediate digits and the index of the link register. One clock later the unit presents the next program counter, a flag saying whether control flow left the straight line, and a return address together with a write strobe for the register file.

There are three kinds of control flow. Sequential instructions advance by one. Conditional branches compare two registers and, when the test holds, move the counter by a signed single-digit offset relative to the current address. Jumps go to an absolute address formed by adding a two-digit constant to a register. A jump also hands back the address after itself as a return address, which allows subroutine calls and returns. All address arithmetic is decimal and wraps modulo 10000.

Top module: `dec_next_pc`

## Requirements
- R1: While rst_n is low every output is 0, and an assertion of rst_n clears the outputs at once without a clock; after rst_n rises, the outputs stay 0 through the first rising clock edge and begin to follow the inputs from the third rising edge on.
- R2: The outputs are registered: they show the result for the inputs sampled at the previous rising clock edge and hold steady between edges.
- R3: With op_i = 0 (sequential) or op_i = 3 (reserved, treated as sequential), npc_o is pc_i + 1 in four-digit BCD with 9999 wrapping to 0000, and taken_o is 0.
- R4: For a branch (op_i = 1) only the low immediate digit imm_i[3:0] is used as offset k: digits 0 to 4 move the counter by +0 to +4 and digits 5 to 9 by -5 to -1; the high immediate digit has no effect; the sum wraps modulo 10000.
- R5: Branch condition cond_i = 0 is taken exactly when ra_val_i equals rb_val_i.
- R6: Condition cond_i = 1 is taken when ra_val_i is greater than rb_val_i and cond_i = 2 when it is less, both comparing signed ten's-complement values (most significant digit 5 to 9 means negative); cond_i = 3 is never taken.
- R7: A branch whose condition fails gives npc_o = pc_i + 1 and taken_o = 0.
- R8: A jump (op_i = 2) gives npc_o = ra_val_i + imm_i (the two immediate digits as a value 0 to 99) modulo 10000, using the register value presented with the jump, and taken_o = 1.
- R9: link_val_o always carries pc_i + 1 of the sampled instruction; link_we_o is 1 only for a jump whose link_idx_i is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pc_i | input | 16 | Current program counter, four BCD digits |
| op_i | input | 2 | Operation class: 0 sequential, 1 branch, 2 jump, 3 reserved |
| cond_i | input | 2 | Branch test: 0 equal, 1 greater, 2 less, 3 never |
| ra_val_i | input | 16 | First register value (branch operand, jump base) |
| rb_val_i | input | 16 | Second register value (branch operand) |
| imm_i | input | 8 | Two BCD immediate digits; low digit is the branch offset |
| link_idx_i | input | 4 | Index of the register that receives the return address |
| npc_o | output | 16 | Next program counter, four BCD digits |
| taken_o | output | 1 | Control flow left the sequential path |
| link_val_o | output | 16 | Return address, pc_i + 1 |
| link_we_o | output | 1 | Write strobe for the return address |

## Verification
The assertions take for granted that every nibble of pc_i, ra_val_i, rb_val_i and imm_i is a decimal digit 0 to 9; the digit-validity property on npc_o only holds under that assumption, and the register file is trusted to present zero for index 0. The stimulus table and the directed tests use only such BCD values, and choose operands that reach each carry and wrap corner, both signs of each compare, both offset extremes and jump bases on either side of the wrap.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    OPC_STEP   = 2'd0,
    OPC_BRANCH = 2'd1,
    OPC_JUMP   = 2'd2,
    OPC_RSVD   = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    CND_EQ   = 2'd0,
    CND_GT   = 2'd1,
    CND_LT   = 2'd2,
    CND_NONE = 2'd3
  } cnd_e;

  // Lowest digit value that marks a ten's-complement negative.
  localparam logic [DIGIT_W-1:0] NEG_DIGIT_MIN = 4'd5;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX     = 4'd9;

endpackage

// File: rtl/dpc_bcd_add.sv
// Ripple adder over DIGITS packed BCD digits; the carry out of the top digit
// is dropped so the sum wraps modulo 10**DIGITS.
module dpc_bcd_add
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGITS*DIGIT_W-1:0] a_i,
  input  logic [DIGITS*DIGIT_W-1:0] b_i,
  input  logic                      cin_i,
  output logic [DIGITS*DIGIT_W-1:0] sum_o
);

  localparam int unsigned RAW_W = DIGIT_W + 1;

  logic [RAW_W-1:0] raw [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic             c_in;
    logic [RAW_W-1:0] fixed;

    if (g == 0) begin : g_first
      assign c_in = cin_i;
    end else begin : g_rest
      assign c_in = (raw[g-1] > RAW_W'(DIGIT_MAX));
    end

    always_comb begin
      raw[g] = {1'b0, a_i[g*DIGIT_W +: DIGIT_W]}
             + {1'b0, b_i[g*DIGIT_W +: DIGIT_W]}
             + {{(RAW_W-1){1'b0}}, c_in};
      if (raw[g] > RAW_W'(DIGIT_MAX)) begin
        fixed = raw[g] - RAW_W'(10);
      end else begin
        fixed = raw[g];
      end
    end

    assign sum_o[g*DIGIT_W +: DIGIT_W] = fixed[DIGIT_W-1:0];
  end

endmodule

// File: rtl/dpc_dec_cmp.sv
// Signed ten's-complement comparison of two BCD words.
module dpc_dec_cmp
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGITS*DIGIT_W-1:0] a_i,
  input  logic [DIGITS*DIGIT_W-1:0] b_i,
  output logic                      eq_o,
  output logic                      gt_o,
  output logic                      lt_o
);

  localparam int unsigned W = DIGITS * DIGIT_W;

  logic neg_a;
  logic neg_b;
  logic mag_gt;
  logic mag_lt;

  // Valid BCD orders the same way as its binary reading, digit by digit.
  assign neg_a  = (a_i[W-1 -: DIGIT_W] >= NEG_DIGIT_MIN);
  assign neg_b  = (b_i[W-1 -: DIGIT_W] >= NEG_DIGIT_MIN);
  assign mag_gt = (a_i > b_i);
  assign mag_lt = (a_i < b_i);

  always_comb begin
    eq_o = (a_i == b_i);
    if (neg_a != neg_b) begin
      gt_o = neg_b;
      lt_o = neg_a;
    end else begin
      gt_o = mag_gt;
      lt_o = mag_lt;
    end
  end

endmodule

// File: rtl/dpc_offset_ext.sv
// Widens one signed offset digit to a ten's-complement word.
module dpc_offset_ext
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGIT_W-1:0]        digit_i,
  output logic [DIGITS*DIGIT_W-1:0] word_o
);

  logic negative;

  assign negative = (digit_i >= NEG_DIGIT_MIN);
  assign word_o[DIGIT_W-1:0] = digit_i;

  for (genvar g = 1; g < DIGITS; g++) begin : g_fill
    assign word_o[g*DIGIT_W +: DIGIT_W] = negative ? DIGIT_MAX : '0;
  end

endmodule

// File: rtl/dpc_next_calc.sv
// Combinational next-state logic: three decimal adders, the compare and the
// path selection.
module dpc_next_calc
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS     = 4,
  parameter int unsigned IMM_DIGITS = 2,
  parameter int unsigned IDX_W      = 4
) (
  input  logic [DIGITS*DIGIT_W-1:0]     pc_i,
  input  logic [1:0]                    op_i,
  input  logic [1:0]                    cond_i,
  input  logic [DIGITS*DIGIT_W-1:0]     ra_i,
  input  logic [DIGITS*DIGIT_W-1:0]     rb_i,
  input  logic [IMM_DIGITS*DIGIT_W-1:0] imm_i,
  input  logic [IDX_W-1:0]              link_idx_i,
  output logic [DIGITS*DIGIT_W-1:0]     npc_o,
  output logic                          taken_o,
  output logic [DIGITS*DIGIT_W-1:0]     link_val_o,
  output logic                          link_we_o
);

  localparam int unsigned W  = DIGITS * DIGIT_W;
  localparam int unsigned IW = IMM_DIGITS * DIGIT_W;

  logic [W-1:0] seq_pc;
  logic [W-1:0] rel_off;
  logic [W-1:0] rel_pc;
  logic [W-1:0] imm_word;
  logic [W-1:0] abs_pc;
  logic         is_eq;
  logic         is_gt;
  logic         is_lt;
  logic         cond_ok;
  opc_e         opc;
  cnd_e         cnd;

  assign opc = opc_e'(op_i);
  assign cnd = cnd_e'(cond_i);

  if (IW < W) begin : g_imm_pad
    assign imm_word = {{(W-IW){1'b0}}, imm_i};
  end else begin : g_imm_full
    assign imm_word = imm_i[W-1:0];
  end

  dpc_bcd_add #(.DIGITS(DIGITS)) u_seq_add (
    .a_i   (pc_i),
    .b_i   ('0),
    .cin_i (1'b1),
    .sum_o (seq_pc)
  );

  dpc_offset_ext #(.DIGITS(DIGITS)) u_off_ext (
    .digit_i (imm_i[DIGIT_W-1:0]),
    .word_o  (rel_off)
  );

  dpc_bcd_add #(.DIGITS(DIGITS)) u_rel_add (
    .a_i   (pc_i),
    .b_i   (rel_off),
    .cin_i (1'b0),
    .sum_o (rel_pc)
  );

  dpc_bcd_add #(.DIGITS(DIGITS)) u_abs_add (
    .a_i   (ra_i),
    .b_i   (imm_word),
    .cin_i (1'b0),
    .sum_o (abs_pc)
  );

  dpc_dec_cmp #(.DIGITS(DIGITS)) u_cmp (
    .a_i  (ra_i),
    .b_i  (rb_i),
    .eq_o (is_eq),
    .gt_o (is_gt),
    .lt_o (is_lt)
  );

  always_comb begin
    unique case (cnd)
      CND_EQ:  cond_ok = is_eq;
      CND_GT:  cond_ok = is_gt;
      CND_LT:  cond_ok = is_lt;
      default: cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    npc_o      = seq_pc;
    taken_o    = 1'b0;
    link_we_o  = 1'b0;
    link_val_o = seq_pc;
    unique case (opc)
      OPC_BRANCH: begin
        if (cond_ok) begin
          npc_o   = rel_pc;
          taken_o = 1'b1;
        end
      end
      OPC_JUMP: begin
        npc_o     = abs_pc;
        taken_o   = 1'b1;
        link_we_o = (link_idx_i != '0);
      end
      default: begin
        npc_o   = seq_pc;
        taken_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dec_next_pc.sv
module dec_next_pc
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS      = 4,
  parameter int unsigned IMM_DIGITS  = 2,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DIGITS*DIGIT_W-1:0]     pc_i,
  input  logic [1:0]                    op_i,
  input  logic [1:0]                    cond_i,
  input  logic [DIGITS*DIGIT_W-1:0]     ra_val_i,
  input  logic [DIGITS*DIGIT_W-1:0]     rb_val_i,
  input  logic [IMM_DIGITS*DIGIT_W-1:0] imm_i,
  input  logic [IDX_W-1:0]              link_idx_i,
  output logic [DIGITS*DIGIT_W-1:0]     npc_o,
  output logic                          taken_o,
  output logic [DIGITS*DIGIT_W-1:0]     link_val_o,
  output logic                          link_we_o
);

  localparam int unsigned W = DIGITS * DIGIT_W;

  // Reset: asserted asynchronously, released after SYNC_STAGES edges.
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic [SYNC_STAGES-1:0] rst_pipe_d;
  logic                   rst_core_n;

  if (SYNC_STAGES > 1) begin : g_sync_multi
    assign rst_pipe_d = {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end else begin : g_sync_one
    assign rst_pipe_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_core_n = rst_pipe_q[SYNC_STAGES-1];

  // Next state.
  logic [W-1:0] npc_d;
  logic         taken_d;
  logic [W-1:0] link_val_d;
  logic         link_we_d;

  dpc_next_calc #(
    .DIGITS     (DIGITS),
    .IMM_DIGITS (IMM_DIGITS),
    .IDX_W      (IDX_W)
  ) u_calc (
    .pc_i       (pc_i),
    .op_i       (op_i),
    .cond_i     (cond_i),
    .ra_i       (ra_val_i),
    .rb_i       (rb_val_i),
    .imm_i      (imm_i),
    .link_idx_i (link_idx_i),
    .npc_o      (npc_d),
    .taken_o    (taken_d),
    .link_val_o (link_val_d),
    .link_we_o  (link_we_d)
  );

  // Output registers.
  logic [W-1:0] npc_q;
  logic         taken_q;
  logic [W-1:0] link_val_q;
  logic         link_we_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      npc_q      <= '0;
      taken_q    <= 1'b0;
      link_val_q <= '0;
      link_we_q  <= 1'b0;
    end else begin
      npc_q      <= npc_d;
      taken_q    <= taken_d;
      link_val_q <= link_val_d;
      link_we_q  <= link_we_d;
    end
  end

  assign npc_o      = npc_q;
  assign taken_o    = taken_q;
  assign link_val_o = link_val_q;
  assign link_we_o  = link_we_q;

endmodule

// File: rtl/dec_next_pc_chk.sv
module dec_next_pc_chk
  import dpc_pkg::*;
#(
  parameter int unsigned DIGITS     = 4,
  parameter int unsigned IMM_DIGITS = 2,
  parameter int unsigned IDX_W      = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [DIGITS*DIGIT_W-1:0]     pc_i,
  input logic [1:0]                    op_i,
  input logic [1:0]                    cond_i,
  input logic [DIGITS*DIGIT_W-1:0]     ra_val_i,
  input logic [DIGITS*DIGIT_W-1:0]     rb_val_i,
  input logic [IMM_DIGITS*DIGIT_W-1:0] imm_i,
  input logic [IDX_W-1:0]              link_idx_i,
  input logic [DIGITS*DIGIT_W-1:0]     npc_o,
  input logic                          taken_o,
  input logic                          link_we_o
);

  localparam int unsigned W = DIGITS * DIGIT_W;

  function automatic logic all_digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(DIGITS); i++) begin
      if (v[i*DIGIT_W +: DIGIT_W] > DIGIT_MAX) ok = 1'b0;
    end
    return ok;
  endfunction

  // R3
  p_step_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd0 || op_i == 2'd3) |=> (!taken_o && !link_we_o));

  // R3: decimal arithmetic never leaves BCD for BCD inputs
  p_npc_digits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    all_digits_ok(npc_o));

  // R4
  p_zero_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd1 && cond_i == 2'd0 && ra_val_i == rb_val_i
     && imm_i[DIGIT_W-1:0] == '0)
    |=> (taken_o && npc_o == $past(pc_i)));

  // R5
  p_equal_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd1 && cond_i == 2'd0 && ra_val_i == rb_val_i) |=> taken_o);

  // R6
  p_never_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd1 && cond_i == 2'd3) |=> !taken_o);

  // R6: equal operands satisfy neither ordering test
  p_order_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd1 && cond_i != 2'd0 && ra_val_i == rb_val_i) |=> !taken_o);

  // R8
  p_direct_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd2 && ra_val_i == '0)
    |=> (taken_o && npc_o == W'($past(imm_i))));

  // R9
  p_link_needs_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> taken_o);

  // R9
  p_link_zero_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 2'd2 && link_idx_i == '0) |=> !link_we_o);

endmodule

bind dec_next_pc dec_next_pc_chk #(
  .DIGITS     (DIGITS),
  .IMM_DIGITS (IMM_DIGITS),
  .IDX_W      (IDX_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .pc_i       (pc_i),
  .op_i       (op_i),
  .cond_i     (cond_i),
  .ra_val_i   (ra_val_i),
  .rb_val_i   (rb_val_i),
  .imm_i      (imm_i),
  .link_idx_i (link_idx_i),
  .npc_o      (npc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o)
);

// File: tb/dec_next_pc_tb_top.sv
`timescale 1ns/1ps
module dec_next_pc_tb_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] pc_i;
  logic [1:0]  op_i;
  logic [1:0]  cond_i;
  logic [15:0] ra_val_i;
  logic [15:0] rb_val_i;
  logic [7:0]  imm_i;
  logic [3:0]  link_idx_i;
  logic [15:0] npc_o;
  logic        taken_o;
  logic [15:0] link_val_o;
  logic        link_we_o;

  int total;
  int bad;
  logic done;

  dec_next_pc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .op_i       (op_i),
    .cond_i     (cond_i),
    .ra_val_i   (ra_val_i),
    .rb_val_i   (rb_val_i),
    .imm_i      (imm_i),
    .link_idx_i (link_idx_i),
    .npc_o      (npc_o),
    .taken_o    (taken_o),
    .link_val_o (link_val_o),
    .link_we_o  (link_we_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  cnd;
    logic [15:0] pc;
    logic [15:0] ra;
    logic [15:0] rb;
    logic [7:0]  imm;
    logic [3:0]  lidx;
    logic [15:0] e_npc;
    logic        e_tk;
    logic        e_we;
    logic [15:0] e_lv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  // op: 0 seq, 1 branch, 2 jump, 3 reserved; cnd: 0 eq, 1 gt, 2 lt, 3 never
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 16'h0041, 16'h0000, 16'h0000, 8'h00, 4'd5, 16'h0042, 1'b0, 1'b0, 16'h0042, 4'd3}, // R3
    '{2'd0, 2'd0, 16'h0099, 16'h0000, 16'h0000, 8'h00, 4'd0, 16'h0100, 1'b0, 1'b0, 16'h0100, 4'd3}, // R3 carry
    '{2'd0, 2'd0, 16'h9999, 16'h0000, 16'h0000, 8'h00, 4'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 4'd3}, // R3 wrap
    '{2'd3, 2'd0, 16'h0010, 16'h1234, 16'h1234, 8'h03, 4'd2, 16'h0011, 1'b0, 1'b0, 16'h0011, 4'd3}, // R3 reserved
    '{2'd1, 2'd0, 16'h0010, 16'h1234, 16'h1234, 8'h73, 4'd9, 16'h0013, 1'b1, 1'b0, 16'h0011, 4'd4}, // R4 high digit ignored
    '{2'd1, 2'd0, 16'h0010, 16'h1234, 16'h1235, 8'h03, 4'd0, 16'h0011, 1'b0, 1'b0, 16'h0011, 4'd5}, // R5 unequal
    '{2'd1, 2'd0, 16'h0010, 16'h1234, 16'h1234, 8'h09, 4'd0, 16'h0009, 1'b1, 1'b0, 16'h0011, 4'd4}, // R4 -1
    '{2'd1, 2'd0, 16'h0010, 16'h1234, 16'h1234, 8'h05, 4'd0, 16'h0005, 1'b1, 1'b0, 16'h0011, 4'd4}, // R4 -5
    '{2'd1, 2'd0, 16'h0098, 16'h0700, 16'h0700, 8'h04, 4'd0, 16'h0102, 1'b1, 1'b0, 16'h0099, 4'd4}, // R4 +4 carry
    '{2'd1, 2'd0, 16'h0050, 16'h0000, 16'h0000, 8'h00, 4'd0, 16'h0050, 1'b1, 1'b0, 16'h0051, 4'd4}, // R4 +0
    '{2'd1, 2'd0, 16'h0002, 16'h0003, 16'h0003, 8'h07, 4'd0, 16'h9999, 1'b1, 1'b0, 16'h0003, 4'd4}, // R4 wrap back
    '{2'd1, 2'd1, 16'h0020, 16'h0005, 16'h0003, 8'h02, 4'd0, 16'h0022, 1'b1, 1'b0, 16'h0021, 4'd6}, // R6 gt pos
    '{2'd1, 2'd1, 16'h0020, 16'h9999, 16'h0001, 8'h02, 4'd0, 16'h0021, 1'b0, 1'b0, 16'h0021, 4'd6}, // R6 -1 > 1 false
    '{2'd1, 2'd1, 16'h0020, 16'h0001, 16'h9999, 8'h02, 4'd0, 16'h0022, 1'b1, 1'b0, 16'h0021, 4'd6}, // R6 1 > -1
    '{2'd1, 2'd2, 16'h0030, 16'h9990, 16'h9995, 8'h03, 4'd0, 16'h0033, 1'b1, 1'b0, 16'h0031, 4'd6}, // R6 -10 < -5
    '{2'd1, 2'd2, 16'h0030, 16'h5000, 16'h4999, 8'h01, 4'd0, 16'h0031, 1'b1, 1'b0, 16'h0031, 4'd6}, // R6 -5000 < 4999
    '{2'd1, 2'd2, 16'h0030, 16'h0007, 16'h0007, 8'h01, 4'd0, 16'h0031, 1'b0, 1'b0, 16'h0031, 4'd7}, // R7 lt equal
    '{2'd1, 2'd1, 16'h0030, 16'h0007, 16'h0007, 8'h01, 4'd0, 16'h0031, 1'b0, 1'b0, 16'h0031, 4'd7}, // R7 gt equal
    '{2'd1, 2'd3, 16'h0030, 16'h0007, 16'h0007, 8'h01, 4'd0, 16'h0031, 1'b0, 1'b0, 16'h0031, 4'd6}, // R6 never
    '{2'd1, 2'd1, 16'h0040, 16'h0000, 16'h9995, 8'h06, 4'd0, 16'h0036, 1'b1, 1'b0, 16'h0041, 4'd6}, // R6 0 > -5, k -4
    '{2'd2, 2'd0, 16'h0005, 16'h0000, 16'h0000, 8'h32, 4'd0, 16'h0032, 1'b1, 1'b0, 16'h0006, 4'd8}, // R8 zero base
    '{2'd2, 2'd0, 16'h0007, 16'h0040, 16'h0000, 8'h15, 4'd9, 16'h0055, 1'b1, 1'b1, 16'h0008, 4'd8}, // R8 call
    '{2'd2, 2'd0, 16'h0210, 16'h0100, 16'h0000, 8'h00, 4'd9, 16'h0100, 1'b1, 1'b1, 16'h0211, 4'd9}, // R9 return
    '{2'd2, 2'd1, 16'h0001, 16'h9990, 16'h1111, 8'h25, 4'd3, 16'h0015, 1'b1, 1'b1, 16'h0002, 4'd8}, // R8 wrap
    '{2'd2, 2'd0, 16'h0800, 16'h0078, 16'h0000, 8'h99, 4'd1, 16'h0177, 1'b1, 1'b1, 16'h0801, 4'd8}  // R8 carries
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pc_i       = v.pc;
    op_i       = v.op;
    cond_i     = v.cnd;
    ra_val_i   = v.ra;
    rb_val_i   = v.rb;
    imm_i      = v.imm;
    link_idx_i = v.lidx;
  endtask

  task automatic chk_all_zero(input string tag);
    chk({tag, " npc"}, npc_o, 16'h0000);
    chk({tag, " taken"}, {15'd0, taken_o}, 16'h0000);
    chk({tag, " link_val"}, link_val_o, 16'h0000);
    chk({tag, " link_we"}, {15'd0, link_we_o}, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    drive(VECS[21]);
    repeat (3) @(negedge clk);
    chk_all_zero("R1 in reset");

    // Release at a falling edge with a jump presented.
    rst_n = 1'b1;
    @(negedge clk);
    chk_all_zero("R1 first edge after release");
    repeat (2) @(negedge clk);
    chk("R1 follows after release", npc_o, 16'h0055);

    // Vector table: drive at a falling edge, sample at the next one.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d npc", VECS[i].req, i), npc_o, VECS[i].e_npc);
      chk($sformatf("R%0d vec%0d taken", VECS[i].req, i), {15'd0, taken_o}, {15'd0, VECS[i].e_tk});
      chk($sformatf("R9 vec%0d link_we", i), {15'd0, link_we_o}, {15'd0, VECS[i].e_we});
      chk($sformatf("R9 vec%0d link_val", i), link_val_o, VECS[i].e_lv);
    end

    // R2: new inputs do not reach the outputs before the rising edge.
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[22]);
    #1;
    chk("R2 hold before edge npc", npc_o, 16'h0042);
    chk("R2 hold before edge link_we", {15'd0, link_we_o}, 16'h0000);
    @(negedge clk);
    chk("R2 after edge npc", npc_o, 16'h0100);
    chk("R2 after edge link_we", {15'd0, link_we_o}, 16'h0001);

    // R1: reset asserted away from any edge clears outputs at once.
    #0.5;
    rst_n = 1'b0;
    #0.5;
    chk_all_zero("R1 async assert");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 after reset link_val", link_val_o, 16'h0211);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule